// File: doc/BRIEF.md
# Mailbox register window with doorbell

This block is the register window of a device-side management mailbox. A host-facing port issues reads and writes of 1, 2, 4 or 8 bytes at naturally aligned byte offsets. The window holds a read-only capability word, a control word that carries a doorbell bit, a 64-bit command word, a status word and a background-status word that only hardware updates, and a byte-addressable payload area. Write data and read data are right-justified: byte 0 of an access sits in bits [7:0], and the bytes follow in little-endian order.

The payload area takes writes of any legal width without further decoding. Writes below the payload follow filtering rules that depend on both the offset and the width. After every accepted write below the payload, the block checks the doorbell. If the doorbell is set, it sends a one-cycle process request to an external command engine. The engine later pulses a completion input together with a return code. That pulse clears the doorbell and records the return code in the status word.

The offset map is: capability at 0x00, control at 0x04, command at 0x08, status at 0x10, background status at 0x18, and payload from 0x20 up to 0x20 + 2^PAYLOAD_LOG2 − 1 (0x81F by default).

Top module: `mbox_regs`

## Requirements
- R1: An access is legal when req_size is 0..3 (1, 2, 4 or 8 bytes), the address is a multiple of the width, and the address lies below the end of the payload. On any other access, a write changes nothing, a read returns 0, and err_flag goes high and stays high until reset.
- R2: A legal write at offset 0x20 or above stores its bytes into payload storage, at any width. Byte k of the data goes to offset addr+k. Payload bytes outside the written width are unchanged.
- R3: The capability word reads 0x0000000B: bits [4:0] hold log2 of the payload size (11), and the interrupt and background-support bits read 0. No write changes it.
- R4: A 4-byte write at 0x04 stores only bit 0 of the data as the doorbell. The control word reads back {31'b0, doorbell}.
- R5: 4-byte writes at other offsets below 0x20, and all 1- and 2-byte writes below 0x20, are ignored.
- R6: An 8-byte write at 0x08 stores the command word. 8-byte writes at 0x00, 0x10 and 0x18 are ignored.
- R7: proc_req is high for exactly the one cycle that follows a legal write below 0x20 after which the doorbell is set. It stays low after payload writes and after writes that leave the doorbell clear.
- R8: A done_pulse clears the doorbell and loads done_code into status bits [47:32], with all other status bits zero. It overrides a control write made in the same cycle, and no proc_req follows that write.
- R9: A read request produces rd_valid in the next cycle. rd_data then holds the addressed bytes in little-endian order, right-justified, with all bytes above the access width at zero.
- R10: After reset the doorbell, command, status, err_flag, proc_req and rd_valid are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset within the window |
| req_size | input | 3 | log2 of the width in bytes; 4..7 are illegal |
| req_wdata | input | 64 | Right-justified little-endian write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 64 | Right-justified little-endian read data |
| proc_req | output | 1 | One-cycle request for the command engine |
| done_pulse | input | 1 | Command completion from the engine |
| done_code | input | CODE_W | Return code loaded on completion |
| err_flag | output | 1 | Sticky flag for illegal accesses |

## Verification
The payload is tried with a full fill of 8-byte words, followed by a seeded random mix of 1-, 2-, 4- and 8-byte writes and reads. These overlap one another, so any error in a byte lane or in the lane order shows up against the byte-level model. Directed writes at every register offset and every width separate the one legal 32-bit target and the one legal 64-bit target from their ignored neighbours. Doorbell writes of 1 and 0 show that proc_req follows the stored bit rather than the mere fact that a write happened. A completion that collides with a doorbell write shows that the completion wins. Misaligned, oversized and out-of-window accesses separate the error path from the normal read path.

// File: rtl/mbox_regs.sv
module mbox_regs #(
  parameter int ADDR_W       = 12,
  parameter int PAYLOAD_LOG2 = 11,
  parameter int CODE_W       = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [2:0]        req_size,
  input  logic [63:0]       req_wdata,
  output logic              rd_valid,
  output logic [63:0]       rd_data,
  output logic              proc_req,
  input  logic              done_pulse,
  input  logic [CODE_W-1:0] done_code,
  output logic              err_flag
);
  localparam int PBYTES = 1 << PAYLOAD_LOG2;
  localparam int PBASE  = 32;
  localparam int WEND   = PBASE + PBYTES;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(8);
  localparam logic [31:0] CAP_VAL = 32'(PAYLOAD_LOG2);

  logic [7:0]  pay [PBYTES];
  logic        db;
  logic [63:0] cmd_q, sts_q;

  wire [3:0] nbytes   = 4'd1 << req_size[1:0];
  wire       size_ok  = !req_size[2];
  wire       align_ok = (req_addr[2:0] & 3'(nbytes - 4'd1)) == 3'd0;
  wire       in_rng   = {{(32-ADDR_W){1'b0}}, req_addr} < 32'(WEND);
  wire       legal    = size_ok & align_ok & in_rng;
  wire       is_pay   = req_addr >= ADDR_W'(PBASE);
  wire [PAYLOAD_LOG2-1:0] poff = PAYLOAD_LOG2'(req_addr - ADDR_W'(PBASE));

  wire wr_ok   = req_valid & req_write & legal;
  wire reg_wr  = wr_ok & ~is_pay;
  wire ctrl_wr = reg_wr & (req_size == 3'd2) & (req_addr == A_CTRL);
  wire cmd_wr  = reg_wr & (req_size == 3'd3) & (req_addr == A_CMD);
  wire db_next = done_pulse ? 1'b0 : (ctrl_wr ? req_wdata[0] : db);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      db       <= 1'b0;
      cmd_q    <= '0;
      sts_q    <= '0;
      err_flag <= 1'b0;
      proc_req <= 1'b0;
    end else begin
      db       <= db_next;
      proc_req <= reg_wr & db_next;
      if (cmd_wr) cmd_q <= req_wdata;
      if (done_pulse) sts_q <= {16'b0, 16'(done_code), 32'b0};
      if (req_valid && !legal) err_flag <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok && is_pay)
      for (int k = 0; k < 8; k++)
        if (k < int'(nbytes))
          pay[poff + PAYLOAD_LOG2'(k)] <= req_wdata[8*k +: 8];
  end

  logic [63:0] word, mask;
  always_comb begin
    word = '0;
    if (is_pay) begin
      for (int k = 0; k < 8; k++)
        word[8*k +: 8] = pay[{poff[PAYLOAD_LOG2-1:3], 3'b000} + PAYLOAD_LOG2'(k)];
    end else begin
      case (req_addr[4:3])
        2'd0:    word = {31'b0, db, CAP_VAL};
        2'd1:    word = cmd_q;
        2'd2:    word = sts_q;
        default: word = '0;
      endcase
    end
    case (req_size[1:0])
      2'd0:    mask = 64'h0000_0000_0000_00FF;
      2'd1:    mask = 64'h0000_0000_0000_FFFF;
      2'd2:    mask = 64'h0000_0000_FFFF_FFFF;
      default: mask = '1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= req_valid & ~req_write;
      if (req_valid && !req_write)
        rd_data <= legal ? ((word >> {req_addr[2:0], 3'b000}) & mask) : 64'd0;
    end
  end
endmodule

module mbox_regs_chk #(parameter int ADDR_W = 12) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [2:0]        req_size,
  input logic              rd_valid,
  input logic              proc_req,
  input logic              done_pulse,
  input logic              err_flag,
  input logic              db,
  input logic [63:0]       sts_q
);
  assert_err_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(err_flag));
  assert_bad_size_flags_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size[2]) |=> err_flag);
  assert_sts_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == ADDR_W'(16) && !done_pulse) |=> $stable(sts_q));
  assert_req_after_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    proc_req |-> ($past(req_valid && req_write) && db));
  assert_done_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> (!db && !proc_req));
  assert_read_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(req_valid && !req_write));
endmodule

bind mbox_regs mbox_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_size(req_size), .rd_valid(rd_valid),
  .proc_req(proc_req), .done_pulse(done_pulse), .err_flag(err_flag),
  .db(db), .sts_q(sts_q)
);

// File: tb/test_mbox_regs.sv
module test_mbox_regs;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 12;
  localparam int PLOG = 11;
  localparam int PBYTES = 1 << PLOG;
  localparam int WEND = 32 + PBYTES;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [2:0] req_size = '0;
  logic [63:0] req_wdata = '0;
  logic rd_valid, proc_req, err_flag;
  logic [63:0] rd_data;
  logic done_pulse = 0;
  logic [15:0] done_code = '0;

  int total = 0, bad = 0;
  logic [7:0] m_pay [PBYTES];
  logic m_db = 0, m_err = 0;
  logic [63:0] m_cmd = 0, m_sts = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbox_regs #(.ADDR_W(ADDR_W), .PAYLOAD_LOG2(PLOG), .CODE_W(16)) i_mbox_regs (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .proc_req(proc_req),
    .done_pulse(done_pulse), .done_code(done_code), .err_flag(err_flag));

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit is_legal(int a, int sz);
    if (sz > 3) return 0;
    if (a % (1 << sz) != 0) return 0;
    return a < WEND;
  endfunction

  function automatic logic [7:0] mbyte(int a);
    if (a < 4) return (a == 0) ? 8'h0B : 8'h00;
    if (a < 8) return (a == 4) ? {7'b0, m_db} : 8'h00;
    if (a < 16) return m_cmd[8*(a-8) +: 8];
    if (a < 24) return m_sts[8*(a-16) +: 8];
    if (a < 32) return 8'h00;
    return m_pay[a-32];
  endfunction

  function automatic logic [63:0] exp_read(int a, int sz);
    logic [63:0] r = '0;
    if (!is_legal(a, sz)) return '0;
    for (int k = 0; k < (1 << sz); k++) r[8*k +: 8] = mbyte(a + k);
    return r;
  endfunction

  task automatic wr(int a, int sz, logic [63:0] d, string tag);
    bit legal = is_legal(a, sz);
    bit exp_req = 0;
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = ADDR_W'(a); req_size = 3'(sz); req_wdata = d;
    if (!legal) m_err = 1;
    else if (a >= 32) begin
      for (int k = 0; k < (1 << sz); k++) m_pay[a-32+k] = d[8*k +: 8];
    end else begin
      if (sz == 2 && a == 4) m_db = d[0];
      if (sz == 3 && a == 8) m_cmd = d;
      exp_req = m_db;
    end
    @(negedge clk);
    req_valid = 0; req_write = 0;
    check({tag, " proc_req"}, {63'b0, proc_req}, {63'b0, exp_req});
    check({tag, " err"}, {63'b0, err_flag}, {63'b0, m_err});
  endtask

  task automatic rd(int a, int sz, string tag);
    logic [63:0] e = exp_read(a, sz);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = ADDR_W'(a); req_size = 3'(sz);
    if (!is_legal(a, sz)) m_err = 1;
    @(negedge clk);
    req_valid = 0;
    check({tag, " rd_valid"}, {63'b0, rd_valid}, 64'd1);
    check({tag, " rd_data"}, rd_data, e);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R10 err", {63'b0, err_flag}, 64'd0);
    check("R10 proc_req", {63'b0, proc_req}, 64'd0);
    check("R10 rd_valid", {63'b0, rd_valid}, 64'd0);
    rd(8, 3, "R10 cmd");
    rd(16, 3, "R10 sts");
    rd(4, 2, "R10 ctrl");

    rd(0, 2, "R3 cap");
    wr(0, 2, 64'hFFFF_FFFF, "R3 capwr");
    rd(0, 3, "R3 cap64");
    wr(0, 3, 64'hFFFF_FFFF_FFFF_FFFF, "R6 wr64 at 0");
    rd(0, 3, "R6 word0");

    wr(8, 3, 64'h0123_4567_89AB_CDEF, "R6 cmd");
    rd(8, 3, "R6 cmd");
    rd(12, 2, "R9 cmd hi");
    rd(9, 0, "R9 byte");
    wr(16, 3, 64'hDEAD_BEEF_0000_1111, "R6 sts");
    wr(24, 3, 64'hDEAD_BEEF_0000_2222, "R6 bgs");
    rd(16, 3, "R6 sts");
    rd(24, 3, "R6 bgs");
    wr(8, 2, 64'hAAAA_5555, "R5 w32 cmd");
    wr(16, 2, 64'h1111_2222, "R5 w32 sts");
    wr(4, 1, 64'h0001, "R5 w16 ctrl");
    wr(4, 0, 64'h01, "R5 w8 ctrl");
    rd(4, 2, "R5 ctrl");
    rd(8, 3, "R5 cmd");

    wr(4, 2, 64'hFFFF_FFFE, "R4 db0 upper bits");
    rd(4, 2, "R4 ctrl");
    wr(4, 2, 64'h0000_0003, "R7 ring");
    rd(4, 2, "R4 ctrl db");
    wr(8, 3, 64'h42, "R7 cmd while db");
    wr(40, 3, 64'h77, "R7 payload no req");
    @(negedge clk);
    done_pulse = 1; done_code = 16'hA5C3;
    m_db = 0; m_sts = 64'hA5C3 << 32;
    @(negedge clk);
    done_pulse = 0;
    check("R8 proc_req", {63'b0, proc_req}, 64'd0);
    rd(4, 2, "R8 ctrl cleared");
    rd(16, 3, "R8 sts code");

    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 4; req_size = 2; req_wdata = 1;
    done_pulse = 1; done_code = 16'h0007;
    m_sts = 64'h7 << 32;
    @(negedge clk);
    req_valid = 0; req_write = 0; done_pulse = 0;
    check("R8 collide proc_req", {63'b0, proc_req}, 64'd0);
    rd(4, 2, "R8 collide ctrl");
    rd(16, 3, "R8 collide sts");

    for (int i = 0; i < PBYTES / 8; i++)
      wr(32 + 8*i, 3, {$urandom, $urandom}, "R2 fill");
    for (int i = 0; i < 400; i++) begin
      int sz = $urandom_range(0, 3);
      int a = 32 + (($urandom_range(0, PBYTES - 1)) & ~((1 << sz) - 1));
      if ($urandom_range(0, 1) == 1) wr(a, sz, {$urandom, $urandom}, "R2 rand wr");
      else rd(a, sz, "R9 rand rd");
    end
    wr(32, 0, 64'hFF_FF_FF_FF_FF_FF_FF_5A, "R2 byte");
    rd(32, 3, "R2 byte lanes");
    rd(WEND - 8, 3, "R2 top word");

    rd(2, 2, "R1 misaligned rd");
    wr(34, 3, 64'h1, "R1 misaligned wr");
    rd(32, 3, "R1 misaligned no effect");
    rd(32, 4, "R1 bad size rd");
    wr(WEND, 0, 64'h1, "R1 out of window");
    rd(WEND, 0, "R1 out of window rd");
    rd(0, 2, "R1 err sticky");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule